// File: doc/BRIEF.md
# Write-Once Configurable Watchdog Timer

This block is a reset-only watchdog for a small microcontroller register bus. It keeps a free-running counter that software must clear in time by writing the reset-status register. If software does not, the block raises a system-reset request for a fixed number of bus clocks. It has no interrupt path. The counter advances on one of two sources. One is a 1 kHz tick, which arrives as a single-cycle clock enable in the bus clock domain. The other is the bus clock itself. Each source offers a short and a long timeout.

Two option registers hold the enable, the timeout length and the source select. Each one accepts only its first write after a system reset, and every later write to it is dropped. Once firmware has committed to an enabled watchdog, it cannot turn the watchdog off again. After each reset the options return to an enabled, long-timeout, tick-driven default. The reset-status register reports whether the latest reset was caused by this watchdog. A separate power-on reset clears that record. A stop-mode input and a debug-mode input freeze or clear the counter, according to the selected source.

Top module: `wonce_watchdog`

## Requirements
- R1: After any system reset the options read back as enabled (option-1 bit 0 = 1), long timeout (option-1 bit 1 = 1) and tick source (option-2 bit 0 = 0), and both option registers can again be written once.
- R2: With the watchdog enabled, the request rises in the cycle after the 2^N-th counting step since the last clear. A step is a cycle with `tick_1k_i` high when option-2 bit 0 = 0, and every cycle when it is 1. N is TICK_SHORT_LOG, TICK_LONG_LOG, BUS_SHORT_LOG or BUS_LONG_LOG, chosen by the source bit and the timeout bit.
- R3: With option-1 bit 0 = 0 the counter stays idle and no request is ever raised.
- R4: Each option register takes only its first write after reset. Later writes change neither its read-back value nor the watchdog's behaviour.
- R5: The accepted write of either option register clears the counter, and the two registers may be written in either order.
- R6: A write of any data to the status register (address 2) clears the counter and leaves the status read-back unchanged.
- R7: With the tick source selected, a cycle with `stop_i` high clears the counter, and counting restarts from zero when stop ends.
- R8: With the bus-clock source selected, `stop_i` holds the counter value, and counting resumes from that value.
- R9: While `dbg_i` is high the counter does not advance, whichever source is selected.
- R10: A timeout drives `wdt_rst_req_o` high for exactly PULSE_LEN consecutive cycles.
- R11: Status bit 0 reads 1 after a system reset that followed a watchdog request, and reads 0 after a system reset with no such request or after a power-on reset.
- R12: Register map: address 0 is option 1 (bit 0 enable, bit 1 long timeout), address 1 is option 2 (bit 0 bus-clock source), address 2 is status (bit 0 watchdog-reset flag). All other bits and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert; the clock runs while it is low |
| por_n | input | 1 | Power-on reset, active low; also clears the watchdog-reset record |
| tick_1k_i | input | 1 | One-cycle enable at the 1 kHz rate |
| stop_i | input | 1 | Stop mode active |
| dbg_i | input | 1 | Debug/background mode active |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| wdt_rst_req_o | output | 1 | System-reset request pulse |

## Verification
A counter off by one step, or a terminal count taken from the wrong source or length, moves the rising edge of `wdt_rst_req_o` by at least one step. The sweep over all four source and length settings therefore catches it in the cycle of the first timeout. If a lock bit stays open, the dropped write shows at once in the option read-back, and a watchdog that can be disabled never fires. Stop and debug handling that clears the counter when it should hold it, or holds it when it should clear it, moves the timeout by the length of the pause. A reset-cause record that is taken at the wrong moment shows as a wrong status bit on the first read after the next reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_OPT1 = 2'd0;
    localparam logic [ADDR_W-1:0] A_OPT2 = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    typedef struct packed {
        logic en;
        logic long_to;
        logic bus_clk;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_optregs.sv
module wdt_optregs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fire_i,
    output wdt_cfg_t          cfg_o,
    output logic              opt1_locked_o,
    output logic              cfg_clr_o,
    output logic              refresh_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        wdt_cfg_t cfg;
        logic     lock1;
        logic     lock2;
    } opt_state_t;

    typedef struct packed {
        logic fired;
        logic flag;
        logic in_rst;
    } cause_state_t;

    localparam wdt_cfg_t CFG_DEFAULT = '{en: 1'b1, long_to: 1'b1, bus_clk: 1'b0};

    opt_state_t   o_d, o_q;
    cause_state_t c_d, c_q;

    always_comb begin
        o_d       = o_q;
        cfg_clr_o = 1'b0;
        refresh_o = 1'b0;
        if (we_i) begin
            unique case (addr_i)
                A_OPT1: if (!o_q.lock1) begin
                    o_d.cfg.en      = wdata_i[0];
                    o_d.cfg.long_to = wdata_i[1];
                    o_d.lock1       = 1'b1;
                    cfg_clr_o       = 1'b1;
                end
                A_OPT2: if (!o_q.lock2) begin
                    o_d.cfg.bus_clk = wdata_i[0];
                    o_d.lock2       = 1'b1;
                    cfg_clr_o       = 1'b1;
                end
                A_STAT:  refresh_o = 1'b1;
                default: ;
            endcase
        end
    end

    // Reset-cause record: captured once, on entry into system reset.
    always_comb begin
        c_d        = c_q;
        c_d.in_rst = !rst_n;
        if (!rst_n) begin
            if (!c_q.in_rst) begin
                c_d.flag  = c_q.fired;
                c_d.fired = 1'b0;
            end
        end else if (fire_i) begin
            c_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.cfg   <= CFG_DEFAULT;
            o_q.lock1 <= 1'b0;
            o_q.lock2 <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            c_q.fired  <= 1'b0;
            c_q.flag   <= 1'b0;
            c_q.in_rst <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_OPT1:  rdata_o[1:0] = {o_q.cfg.long_to, o_q.cfg.en};
            A_OPT2:  rdata_o[0]   = o_q.cfg.bus_clk;
            A_STAT:  rdata_o[0]   = c_q.flag;
            default: rdata_o      = '0;
        endcase
    end

    assign cfg_o         = o_q.cfg;
    assign opt1_locked_o = o_q.lock1;
    assign flag_o        = c_q.flag;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned TICK_SHORT_LOG = 5,
    parameter int unsigned TICK_LONG_LOG  = 8,
    parameter int unsigned BUS_SHORT_LOG  = 13,
    parameter int unsigned BUS_LONG_LOG   = 18,
    parameter int unsigned CNT_W          = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdt_cfg_t         cfg_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             stop_i,
    input  logic             dbg_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TERM_TS = CNT_W'((64'd1 << TICK_SHORT_LOG) - 64'd1);
    localparam logic [CNT_W-1:0] TERM_TL = CNT_W'((64'd1 << TICK_LONG_LOG) - 64'd1);
    localparam logic [CNT_W-1:0] TERM_BS = CNT_W'((64'd1 << BUS_SHORT_LOG) - 64'd1);
    localparam logic [CNT_W-1:0] TERM_BL = CNT_W'((64'd1 << BUS_LONG_LOG) - 64'd1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [CNT_W-1:0] term;
    logic             adv;
    logic             zap;

    always_comb begin
        s_d    = s_q;
        fire_o = 1'b0;
        if (cfg_i.bus_clk) term = cfg_i.long_to ? TERM_BL : TERM_BS;
        else               term = cfg_i.long_to ? TERM_TL : TERM_TS;
        adv = (cfg_i.bus_clk | tick_i) & ~stop_i & ~dbg_i;
        zap = ~cfg_i.en | clr_i | (stop_i & ~cfg_i.bus_clk);
        if (zap) begin
            s_d.cnt = '0;
        end else if (adv) begin
            if (s_q.cnt == term) begin
                s_d.cnt = '0;
                fire_o  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.cnt <= '0;
        else        s_q     <= s_d;
    end

    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic req_o
);
    localparam int unsigned PC_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PC_W-1:0] left;
    } pulse_state_t;

    pulse_state_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (fire_i)             p_d.left = PC_W'(PULSE_LEN);
        else if (p_q.left != 0) p_d.left = p_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q.left <= '0;
        else        p_q      <= p_d;
    end

    assign req_o = (p_q.left != '0);
endmodule

// File: rtl/wonce_watchdog.sv
module wonce_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned TICK_SHORT_LOG = 5,
    parameter int unsigned TICK_LONG_LOG  = 8,
    parameter int unsigned BUS_SHORT_LOG  = 13,
    parameter int unsigned BUS_LONG_LOG   = 18,
    parameter int unsigned PULSE_LEN      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        tick_1k_i,
    input  logic        stop_i,
    input  logic        dbg_i,
    input  logic        bus_we_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [7:0]  bus_wdata_i,
    output logic [7:0]  bus_rdata_o,
    output logic        wdt_rst_req_o
);
    localparam int unsigned MAX_T = (TICK_SHORT_LOG > TICK_LONG_LOG) ? TICK_SHORT_LOG : TICK_LONG_LOG;
    localparam int unsigned MAX_B = (BUS_SHORT_LOG > BUS_LONG_LOG) ? BUS_SHORT_LOG : BUS_LONG_LOG;
    localparam int unsigned CNT_W = (MAX_T > MAX_B) ? MAX_T : MAX_B;

    wdt_cfg_t         cfg;
    logic             opt1_locked;
    logic             cfg_clr;
    logic             refresh;
    logic             rst_flag;
    logic             fire;
    logic [CNT_W-1:0] wd_cnt;

    wdt_optregs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .por_n         (por_n),
        .we_i          (bus_we_i),
        .addr_i        (bus_addr_i),
        .wdata_i       (bus_wdata_i),
        .fire_i        (fire),
        .cfg_o         (cfg),
        .opt1_locked_o (opt1_locked),
        .cfg_clr_o     (cfg_clr),
        .refresh_o     (refresh),
        .flag_o        (rst_flag),
        .rdata_o       (bus_rdata_o)
    );

    wdt_counter #(
        .TICK_SHORT_LOG (TICK_SHORT_LOG),
        .TICK_LONG_LOG  (TICK_LONG_LOG),
        .BUS_SHORT_LOG  (BUS_SHORT_LOG),
        .BUS_LONG_LOG   (BUS_LONG_LOG),
        .CNT_W          (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_i  (cfg),
        .clr_i  (cfg_clr | refresh),
        .tick_i (tick_1k_i),
        .stop_i (stop_i),
        .dbg_i  (dbg_i),
        .fire_o (fire),
        .cnt_o  (wd_cnt)
    );

    wdt_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .req_o  (wdt_rst_req_o)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W     = 18,
    parameter int unsigned PULSE_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              stop_i,
    input logic              dbg_i,
    input wdt_cfg_t          cfg_i,
    input logic              lock1_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              flag_i,
    input logic              req_i
);
    localparam int unsigned RW = $clog2(PULSE_LEN + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           run_q <= '0;
        else if (!req_i)                      run_q <= '0;
        else if (run_q != RW'(PULSE_LEN + 1)) run_q <= run_q + 1'b1;
    end

    p_pulse_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_i) |-> run_q == RW'(PULSE_LEN));

    p_pulse_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(PULSE_LEN));

    p_req_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_i) |-> $past(cfg_i.en));

    p_locked_opt1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock1_i && we_i && addr_i == A_OPT1) |=> ($stable(cfg_i.en) && $stable(cfg_i.long_to)));

    p_refresh_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_STAT) |=> cnt_i == '0);

    p_status_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_STAT) |=> $stable(flag_i));

    p_stop_tick_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !cfg_i.bus_clk) |=> cnt_i == '0);

    p_dbg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_i && !stop_i && !we_i) |=> $stable(cnt_i));
endmodule

bind wonce_watchdog wdt_checker #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .stop_i  (stop_i),
    .dbg_i   (dbg_i),
    .cfg_i   (cfg),
    .lock1_i (opt1_locked),
    .cnt_i   (wd_cnt),
    .flag_i  (rst_flag),
    .req_i   (wdt_rst_req_o)
);

// File: tb/wonce_watchdog_tb.sv
`timescale 1ns/1ps
module wonce_watchdog_tb;
    localparam int TS = 3, TL = 5, BS = 4, BL = 6, PL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0;
    logic       tick = 1'b0, stop = 1'b0, dbg = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       req;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wonce_watchdog #(
        .TICK_SHORT_LOG (TS), .TICK_LONG_LOG (TL),
        .BUS_SHORT_LOG  (BS), .BUS_LONG_LOG  (BL),
        .PULSE_LEN      (PL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .por_n (por_n),
        .tick_1k_i (tick), .stop_i (stop), .dbg_i (dbg),
        .bus_we_i (we), .bus_addr_i (addr), .bus_wdata_i (wdata),
        .bus_rdata_o (rdata), .wdt_rst_req_o (req)
    );

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic sys_reset();
        @(negedge clk);
        tick = 0; stop = 0; dbg = 0; we = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode: 0 plain, 1 stop pause, 2 debug pause. Entered at a negedge right after the clearing edge.
    task automatic run_fire(input bit bus, input int nlog, input int mode, input string rq);
        int steps = 0, pause_left = 0, n = 0;
        bit did = 0, seen = 0;
        int half = (1 << nlog) / 2;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (req) begin seen = 1; break; end
            if (pause_left == 0 && mode != 0 && !did && steps == half) begin
                pause_left = 10; did = 1;
            end
            if (pause_left > 0) begin
                stop = (mode == 1); dbg = (mode == 2);
                tick = !bus && (cyc % 3 == 0);
                if (mode == 1 && !bus) steps = 0;
                pause_left--;
            end else begin
                stop = 0; dbg = 0;
                tick = !bus && (cyc % 3 == 0);
                if (bus || tick) steps++;
            end
            @(negedge clk);
        end
        tick = 0; stop = 0; dbg = 0;
        check({rq, " request seen"}, int'(seen), 1);
        check({rq, " steps to request"}, steps, 1 << nlog);
        while (req && n < 20) begin n++; @(negedge clk); end
        check("R10 pulse length", n, PL);
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int v;
        int hits;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        check("R10 no request after power-on", int'(req), 0);
        do_read(2'd0, v); check("R1 opt1 default", v, 3);
        do_read(2'd1, v); check("R1 opt2 default", v, 0);
        do_read(2'd2, v); check("R11 flag after power-on", v, 0);
        do_read(2'd3, v); check("R12 unused address", v, 0);

        // R5: counter already partway under defaults; the first option write clears it.
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); tick = (i % 3 == 0);
        end
        @(negedge clk); tick = 0;
        check("R5 no early request", int'(req), 0);
        do_write(2'd0, 8'h03);
        run_fire(0, TL, 0, "R5");
        sys_reset();
        do_read(2'd2, v); check("R11 flag after watchdog reset", v, 1);
        do_read(2'd0, v); check("R1 opt1 back to default", v, 3);

        // R2 sweep over source and length, alternating write order (R5), plus locking (R4).
        for (int c = 0; c < 4; c++) begin
            bit b  = c[1];
            bit lg = c[0];
            int nl = b ? (lg ? BL : BS) : (lg ? TL : TS);
            sys_reset();
            if (c % 2 == 0) begin
                do_write(2'd0, {6'd0, lg, 1'b1}); do_write(2'd1, {7'd0, b});
            end else begin
                do_write(2'd1, {7'd0, b}); do_write(2'd0, {6'd0, lg, 1'b1});
            end
            do_read(2'd0, v); check("R12 opt1 readback", v, 1 + 2 * int'(lg));
            do_read(2'd1, v); check("R12 opt2 readback", v, int'(b));
            do_write(2'd2, 8'h00);
            run_fire(b, nl, 0, "R2");
            do_write(2'd0, 8'h00);
            do_write(2'd1, {7'd0, ~b});
            do_read(2'd0, v); check("R4 opt1 locked", v, 1 + 2 * int'(lg));
            do_read(2'd1, v); check("R4 opt2 locked", v, int'(b));
            do_write(2'd2, 8'h5A);
            run_fire(b, nl, 0, "R4");
            sys_reset();
            do_read(2'd2, v); check("R11 flag set", v, 1);
        end
        sys_reset();
        do_read(2'd2, v); check("R11 flag cleared by plain reset", v, 0);

        // R3 disabled, then R4 re-enable attempt ignored
        sys_reset();
        do_write(2'd0, 8'h00); do_write(2'd1, 8'h01);
        hits = 0;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (req) hits++; end
        check("R3 disabled never requests", hits, 0);
        do_write(2'd0, 8'h01);
        do_read(2'd0, v); check("R4 disable cannot be undone", v, 0);
        hits = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (req) hits++; end
        check("R4 still no request", hits, 0);

        // R6 refresh keeps it quiet, status unchanged
        sys_reset();
        do_write(2'd1, 8'h01); do_write(2'd0, 8'h01);
        hits = 0;
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < 10; i++) begin @(negedge clk); if (req) hits++; end
            do_write(2'd2, 8'hFF);
        end
        check("R6 refreshed never requests", hits, 0);
        do_read(2'd2, v); check("R6 status unchanged", v, 0);
        do_write(2'd2, 8'hFF);
        run_fire(1, BS, 0, "R6");

        sys_reset();
        do_write(2'd0, 8'h03); do_write(2'd1, 8'h01);
        run_fire(1, BL, 1, "R8");

        sys_reset();
        do_write(2'd0, 8'h01); do_write(2'd1, 8'h00);
        run_fire(0, TS, 1, "R7");

        sys_reset();
        do_write(2'd0, 8'h01); do_write(2'd1, 8'h01);
        run_fire(1, BS, 2, "R9");
        sys_reset();
        do_write(2'd0, 8'h03); do_write(2'd1, 8'h00);
        run_fire(0, TL, 2, "R9");

        // R11 power-on reset clears the record even after a watchdog request
        @(negedge clk);
        por_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        do_read(2'd2, v); check("R11 power-on clears flag", v, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule